// File: doc/BRIEF.md
# Radix-2 Single-Delay-Feedback FFT Stage

This block is one pipelined stage of a streaming radix-2 decimation-in-time FFT in the single-delay-feedback arrangement. It takes one complex fixed-point sample per clock, marked by a valid flag. It pairs each sample with the one that arrived `DEPTH` accepted samples earlier, and emits one complex result per accepted sample on a registered output. The pairing uses a feedback shift chain of `DEPTH` complex words. The later sample of each pair is first rotated by a twiddle factor from a generated table, and the pair then goes through a scaled add/subtract butterfly. The sum leaves the stage at once. The difference goes back into the chain and leaves `DEPTH` accepted samples later.

An external phase select, normally one bit of a central control counter, switches every `DEPTH` accepted samples. While it is low, incoming samples are loaded into the chain and the stored differences drain out. While it is high, the butterfly runs. A stage-enable input freezes the whole stage so that it can be gated off when the configured transform length does not need it. Output reordering and the chaining of several stages are left to the surrounding pipeline.

Top module: `r2sdf_stage`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` becomes 0 and `out_re`/`out_im` become 0 after that edge.
- R2: A sample is accepted on an edge where `in_valid` and `stage_en` are both 1. `out_valid` is 1 after that edge only if the accepted sample had `bfly_sel` = 1 or an earlier sample since reset did; otherwise it is 0.
- R3: For a sample accepted with `bfly_sel` = 1, the output after that edge is `(a + t) >>> 1` for each of the real and imaginary parts. Here `a` is the sample accepted `DEPTH` accepted samples earlier, `t` is the current sample multiplied by twiddle W[k], and `>>>` is an arithmetic (floor) shift.
- R4: For a sample accepted with `bfly_sel` = 0 after the stage has been primed, the output is the difference `(a - t) >>> 1` formed `DEPTH` accepted samples earlier.
- R5: Twiddle W[k] has real part round(32767·cos(πk/DEPTH)) and imaginary part round(−32767·sin(πk/DEPTH)), rounding half away from zero. k is the number of samples accepted since reset, modulo `DEPTH`.
- R6: The complex product is formed at full precision. Each part is then rounded as `(p + 2^14) >>> 15` and saturated to the range −32768..32767, so it never wraps.
- R7: On an edge with `stage_en` = 0, no sample is accepted, `out_valid` becomes 0, `out_re`/`out_im` hold their values, and the stage's internal state does not advance. The state shows later in the outputs.
- R8: On an edge with `in_valid` = 0, the same holds as for R7: no state change, `out_valid` 0, and the output data held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_en | input | 1 | Stage enable; 0 freezes the stage |
| in_valid | input | 1 | Input sample valid |
| bfly_sel | input | 1 | Phase select: 0 load chain / drain differences, 1 butterfly |
| in_re | input | DW | Input sample, real part, two's complement |
| in_im | input | DW | Input sample, imaginary part, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_re | output | DW | Output sample, real part |
| out_im | output | DW | Output sample, imaginary part |

## Verification
A wrong twiddle address or multiplier rounding corrupts the very next sum, one clock after the offending sample is accepted. A fault in the feedback chain shows up `DEPTH` accepted samples later, when the stored difference drains out. Stall cycles, with the input idle or the stage disabled, are placed inside a frame. Any hidden advance of the counter or the chain therefore misaligns every later pair. Saturation is driven at both extremes through a 45° twiddle.

// File: rtl/r2sdf_pkg.sv
package r2sdf_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Quantise a real value in [-1,1] to a signed integer of given full scale,
  // rounding half away from zero.
  function automatic int tw_quant(input real v, input int scale);
    real s;
    s = v * scale;
    if (s >= 0.0) return $rtoi(s + 0.5);
    else          return $rtoi(s - 0.5);
  endfunction

endpackage

// File: rtl/sdf_stage_ctrl.sv
module sdf_stage_ctrl #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          bfly_sel,
  output logic [AW-1:0] tw_addr,
  output logic          primed
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // Wrapping up-counter over accepted samples; addresses the twiddle table.
  always_ff @(posedge clk) begin
    if (rst) begin
      tw_addr <= '0;
    end else if (accept) begin
      if (tw_addr == LAST) tw_addr <= '0;
      else                 tw_addr <= tw_addr + 1'b1;
    end
  end

  // Set once the first butterfly phase has been seen: from then on the
  // feedback chain holds differences worth draining.
  always_ff @(posedge clk) begin
    if (rst)                      primed <= 1'b0;
    else if (accept && bfly_sel)  primed <= 1'b1;
  end

endmodule

// File: rtl/sdf_twiddle_rom.sv
module sdf_twiddle_rom #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic [AW-1:0]        addr,
  output logic signed [DW-1:0] w_re,
  output logic signed [DW-1:0] w_im
);
  import r2sdf_pkg::*;

  localparam int SCALE = (1 << (DW - 1)) - 1;

  logic signed [DW-1:0] rom_re [DEPTH];
  logic signed [DW-1:0] rom_im [DEPTH];

  // Table entries computed at elaboration: W[k] = exp(-j*pi*k/DEPTH).
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam real ANG = PI_R * i / DEPTH;
    assign rom_re[i] = DW'(tw_quant($cos(ANG), SCALE));
    assign rom_im[i] = DW'(tw_quant(-$sin(ANG), SCALE));
  end

  // Unregistered read, one table per component.
  assign w_re = rom_re[addr];
  assign w_im = rom_im[addr];

endmodule

// File: rtl/sdf_cmult.sv
module sdf_cmult #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic signed [DW-1:0] p_re,
  output logic signed [DW-1:0] p_im
);

  localparam int PW = 2 * DW + 1;
  localparam int SH = DW - 1;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(1 << (DW - 1));

  logic signed [2*DW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [PW-1:0]   acc_re, acc_im;

  assign m_rr = b_re * w_re;
  assign m_ii = b_im * w_im;
  assign m_ri = b_re * w_im;
  assign m_ir = b_im * w_re;

  assign acc_re = PW'(m_rr) - PW'(m_ii);
  assign acc_im = PW'(m_ri) + PW'(m_ir);

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] r;
    r = (v + RND) >>> SH;
    if (r > MAXV)      return MAXV[DW-1:0];
    else if (r < MINV) return MINV[DW-1:0];
    else               return DW'(r);
  endfunction

  assign p_re = rnd_sat(acc_re);
  assign p_im = rnd_sat(acc_im);

endmodule

// File: rtl/sdf_butterfly.sv
module sdf_butterfly #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] t_re,
  input  logic signed [DW-1:0] t_im,
  output logic signed [DW-1:0] s_re,
  output logic signed [DW-1:0] s_im,
  output logic signed [DW-1:0] d_re,
  output logic signed [DW-1:0] d_im
);

  logic signed [DW:0] sr, si, dr, di;

  // One guard bit, then a floor shift keeps every result in range.
  assign sr = (DW+1)'(a_re) + (DW+1)'(t_re);
  assign si = (DW+1)'(a_im) + (DW+1)'(t_im);
  assign dr = (DW+1)'(a_re) - (DW+1)'(t_re);
  assign di = (DW+1)'(a_im) - (DW+1)'(t_im);

  assign s_re = DW'(sr >>> 1);
  assign s_im = DW'(si >>> 1);
  assign d_re = DW'(dr >>> 1);
  assign d_im = DW'(di >>> 1);

endmodule

// File: rtl/sdf_delay_line.sv
module sdf_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         shift_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap
);

  logic [W-1:0] chain [DEPTH];

  // Plain shift chain without reset; only read once filled.
  always_ff @(posedge clk) begin
    if (shift_en) begin
      chain[0] <= din;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  assign tap = chain[DEPTH-1];

endmodule

// File: rtl/r2sdf_stage.sv
module r2sdf_stage #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stage_en,
  input  logic                 in_valid,
  input  logic                 bfly_sel,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  logic                 accept;
  logic [AW-1:0]        tw_addr;
  logic                 primed;
  logic signed [DW-1:0] w_re, w_im, t_re, t_im;
  logic signed [DW-1:0] s_re, s_im, d_re, d_im;
  logic [2*DW-1:0]      fb_in, fb_tap;
  logic signed [DW-1:0] a_re, a_im;

  assign accept = in_valid & stage_en;

  sdf_stage_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .bfly_sel(bfly_sel),
    .tw_addr(tw_addr), .primed(primed)
  );

  sdf_twiddle_rom #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rom (
    .addr(tw_addr), .w_re(w_re), .w_im(w_im)
  );

  sdf_cmult #(.DW(DW)) u_mul (
    .b_re(in_re), .b_im(in_im), .w_re(w_re), .w_im(w_im),
    .p_re(t_re), .p_im(t_im)
  );

  assign a_re = fb_tap[2*DW-1:DW];
  assign a_im = fb_tap[DW-1:0];

  sdf_butterfly #(.DW(DW)) u_bf (
    .a_re(a_re), .a_im(a_im), .t_re(t_re), .t_im(t_im),
    .s_re(s_re), .s_im(s_im), .d_re(d_re), .d_im(d_im)
  );

  // Load phase stores raw input; butterfly phase stores the difference.
  assign fb_in = bfly_sel ? {d_re, d_im} : {in_re, in_im};

  sdf_delay_line #(.W(2*DW), .DEPTH(DEPTH)) u_fb (
    .clk(clk), .shift_en(accept), .din(fb_in), .tap(fb_tap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= accept & (primed | bfly_sel);
      if (accept && (primed || bfly_sel)) begin
        out_re <= bfly_sel ? s_re : a_re;
        out_im <= bfly_sel ? s_im : a_im;
      end
    end
  end

endmodule

// File: rtl/r2sdf_stage_chk.sv
module r2sdf_stage_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stage_en,
  input logic                 in_valid,
  input logic                 bfly_sel,
  input logic signed [DW-1:0] out_re,
  input logic signed [DW-1:0] out_im,
  input logic                 out_valid
);

  logic seen_bfly;
  always_ff @(posedge clk) begin
    if (rst)                                    seen_bfly <= 1'b0;
    else if (in_valid && stage_en && bfly_sel)  seen_bfly <= 1'b1;
  end

  // R7: disabled stage produces no output beat
  p_gated_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !stage_en |=> !out_valid);

  // R7: disabled stage holds its output data
  p_gated_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stage_en |=> ($stable(out_re) && $stable(out_im)));

  // R8: idle input produces no output beat
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2: no output before the first butterfly-phase sample since reset
  p_primed_first_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen_bfly);

endmodule

bind r2sdf_stage r2sdf_stage_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_r2sdf_stage.sv
`timescale 1ns/1ps
module sim_r2sdf_stage;

  localparam int DW = 16;
  localparam int D  = 4;
  localparam int NV = 24;

  localparam int STIM_RE [NV] = '{100, 200, -300, 400, 1000, -2000, 3000, -4000,
                                   500, 600, 700, 800, 32767, 32767, -32768, 12345,
                                   7, -7, 9, -9, -32768, -32768, 32767, 1};
  localparam int STIM_IM [NV] = '{50, -60, 70, -80, 900, 800, -700, 600,
                                   -1, 2, -3, 4, 32767, 32767, -32768, -12345,
                                   0, 0, 0, 0, -32768, -32768, 32767, -1};

  logic clk = 1'b0;
  logic rst, stage_en, in_valid, bfly_sel;
  logic signed [DW-1:0] in_re, in_im, out_re, out_im;
  logic out_valid;

  always #2.5 clk = ~clk;

  r2sdf_stage #(.DW(DW), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .stage_en(stage_en), .in_valid(in_valid),
    .bfly_sel(bfly_sel), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int nchk = 0, nfail = 0, nacc = 0;
  int hre [64];
  int him [64];
  int last_re = 0, last_im = 0;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R5: twiddle quantisation
  function automatic int q15(input real v);
    real s;
    s = v * 32767.0;
    return (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
  endfunction

  // R6: rounding and saturation of a full-precision product
  function automatic int rsat(input longint p);
    longint r;
    r = (p + 16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  task automatic rotate(input int br, input int bi, input int k,
                        output int tr, output int ti);
    real ang;
    int wr, wi;
    ang = 3.14159265358979323846 * k / D;
    wr = q15($cos(ang));
    wi = q15(-$sin(ang));
    tr = rsat(longint'(br) * wr - longint'(bi) * wi);
    ti = rsat(longint'(br) * wi + longint'(bi) * wr);
  endtask

  task automatic apply(input bit v, input bit en, input int re, input int im);
    bit sel;
    int n, tr, ti, er, ei;
    sel = ((nacc / D) % 2) == 1;
    in_valid = v; stage_en = en; bfly_sel = sel;
    in_re = DW'(re); in_im = DW'(im);
    @(negedge clk);
    if (v && en) begin
      n = nacc;
      hre[n] = re; him[n] = im;
      nacc++;
      if (sel) begin
        rotate(re, im, n % D, tr, ti);
        er = (hre[n-D] + tr) >>> 1;
        ei = (him[n-D] + ti) >>> 1;
        check("R2 valid on butterfly beat", int'(out_valid), 1);
        check("R3/R5/R6 sum real", int'(out_re), er);
        check("R3/R5/R6 sum imag", int'(out_im), ei);
      end else if (n >= 2*D) begin
        rotate(hre[n-D], him[n-D], (n-D) % D, tr, ti);
        er = (hre[n-2*D] - tr) >>> 1;
        ei = (him[n-2*D] - ti) >>> 1;
        check("R2 valid on drain beat", int'(out_valid), 1);
        check("R4 difference real", int'(out_re), er);
        check("R4 difference imag", int'(out_im), ei);
      end else begin
        check("R2 no output before priming", int'(out_valid), 0);
      end
    end else begin
      check(en ? "R8 idle valid low" : "R7 disabled valid low", int'(out_valid), 0);
      check(en ? "R8 idle data held" : "R7 disabled data held", int'(out_re), last_re);
      check(en ? "R8 idle data held im" : "R7 disabled data held im", int'(out_im), last_im);
    end
    last_re = int'(out_re);
    last_im = int'(out_im);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; stage_en = 1'b0; in_valid = 1'b0; bfly_sel = 1'b0;
    in_re = '0; in_im = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset re", int'(out_re), 0);
    check("R1 reset im", int'(out_im), 0);
    rst = 1'b0;

    // Main vector table, with stalls inserted mid-frame
    for (int i = 0; i < NV; i++) begin
      if (i == 10) begin
        apply(1'b0, 1'b1, 31111, -31111);  // R8
        apply(1'b1, 1'b0, -2222, 2222);    // R7
        apply(1'b0, 1'b0, 5, 5);           // R7
      end
      if (i == 14) apply(1'b1, 1'b0, 9999, 9999); // R7 during butterfly phase
      apply(1'b1, 1'b1, STIM_RE[i], STIM_IM[i]);
    end
    // Drain the last frame's differences (R4)
    for (int i = 0; i < D; i++) apply(1'b1, 1'b1, 0, 0);

    // Reset in the middle of operation, then restart (R1, R2)
    rst = 1'b1; in_valid = 1'b1; stage_en = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset valid", int'(out_valid), 0);
    check("R1 mid-run reset re", int'(out_re), 0);
    rst = 1'b0;
    nacc = 0; last_re = 0; last_im = 0;
    for (int i = 0; i < 2*D; i++) apply(1'b1, 1'b1, 1000*(i+1), -500*i);
    for (int i = 0; i < D; i++) apply(1'b1, 1'b1, -77, 33);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule